// File: doc/BRIEF.md
# Dual-Channel Phase-Frequency Detector with Lock Monitor and Status Selector

This block holds two identical digital phase-frequency detectors, channel 0 for the intermediate-frequency loop and channel 1 for the radio-frequency loop. Each detector watches the rising edges of a divided reference stream and a divided feedback stream, both synchronous to the system clock, and turns their order of arrival into pump-up and pump-down requests for an external charge pump. A per-channel polarity bit adapts the detector to a VCO whose frequency rises or falls with tuning voltage. A high-impedance bit or a power-down bit silences both requests.

Each channel also carries a lock monitor. It measures every comparison in system clocks and declares lock once a programmable run of consecutive comparisons has stayed within a width limit. A single status pin, steered by a 4-bit select code, shows a lock flag, one of the divider streams, or a constant low. Some codes instead raise a fast-lock request or counter-reset commands for the dividers of one or both channels.

The detector state machine has four states: `PD_IDLE` (no edge pending), `PD_REF_LEAD` (reference edge seen, feedback awaited), `PD_FB_LEAD` (feedback edge seen, reference awaited) and `PD_BOTH` (both seen, cleared on the next clock). Its transitions are: idle to ref-lead on a reference edge alone; idle to fb-lead on a feedback edge alone; idle to both on simultaneous edges; ref-lead to both on a feedback edge; fb-lead to both on a reference edge; both back to idle, or to whichever state the edges of that cycle select; any state to idle while powered down. The lock monitor has two states: `LK_HUNT` (counting good comparisons) and `LK_HELD` (lock declared). It moves from hunt to held when the run count is reached. It moves from held to hunt when a pulse grows too wide or the channel is powered down.

Top module: `pfd_lock_mux`

## Requirements
- R1: After reset all pump requests, lock flags, the status pin, the fast-lock request and the counter-reset bits are low.
- R2: With `pol_pos` high, a reference edge arriving d clocks before the feedback edge raises `pump_up` for d+1 clocks, the clock after the reference edge being the first. `pump_dn` is high only during the last of those clocks.
- R3: With `pol_pos` low, the roles are swapped: a feedback edge that leads by d clocks raises `pump_up` for d+1 clocks, and `pump_dn` is high only in the last one.
- R4: When both requests are active together, both fall one clock later. Simultaneous edges give exactly one clock with both high.
- R5: While `cp_hiz` or `pwr_dn` of a channel is high, both of its pump requests are low. A power-down also drops a pending comparison and the lock flag, so after release no request is active until the next edge.
- R6: `locked` rises after `LOCK_COUNT` consecutive comparisons whose lead time is at most `LOCK_THRESH` clocks. A lead of exactly `LOCK_THRESH` keeps an existing lock.
- R7: `locked` falls as soon as a lead lasts longer than `LOCK_THRESH` clocks, and the run count starts again from zero.
- R8: Repeated edges on the leading stream with no edge on the other keep the same request asserted: the detector is also a frequency detector.
- R9: Select codes (bit3..bit0) 0100, 1000 and 1100 give the channel 0 lock view, the channel 1 lock view, and the AND of both. A lock view is high while locked and low during each lead pulse.
- R10: Select codes 0001 and 0010 route the reference input of channel 0 and channel 1. Codes 0101 and 0110 route their feedback inputs.
- R11: Select code 0011 drives the status pin low and raises `fast_lock`.
- R12: Select codes 0111, 1011 and 1111 raise `cnt_rst` bit 0, bit 1 and both bits, with the status pin low.
- R13: Select code 0000 and the unassigned codes 1001, 1010, 1101 and 1110 give a low status pin, no fast-lock request and no counter reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 2 | Divided reference stream per channel (bit 0 IF, bit 1 RF) |
| fb_pulse | input | 2 | Divided feedback stream per channel |
| pol_pos | input | 2 | 1: VCO frequency rises with tuning voltage |
| cp_hiz | input | 2 | Force both pump requests inactive |
| pwr_dn | input | 2 | Channel power-down |
| stat_sel | input | 4 | Status selector code |
| pump_up | output | 2 | Charge-pump source request per channel |
| pump_dn | output | 2 | Charge-pump sink request per channel |
| locked | output | 2 | Lock flag per channel |
| stat_out | output | 1 | Multiplexed status pin |
| fast_lock | output | 1 | Fast-lock request (status pin pulled low) |
| cnt_rst | output | 2 | Divider reset command per channel |

## Verification
The bench builds the block with `LOCK_THRESH` = 2 and `LOCK_COUNT` = 4. With these values the lock run finishes within a few dozen clocks. Lead widths of 2 (kept) and 4 (dropped) sit on both sides of the width limit. The lead counter's saturation point at three is also reached.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    localparam int NUM_CH = 2;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        PD_IDLE     = 2'd0,
        PD_REF_LEAD = 2'd1,
        PD_FB_LEAD  = 2'd2,
        PD_BOTH     = 2'd3
    } pd_state_t;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lk_state_t;

    typedef enum logic [3:0] {
        ST_OFF     = 4'b0000,
        ST_REF0    = 4'b0001,
        ST_REF1    = 4'b0010,
        ST_FAST    = 4'b0011,
        ST_LOCK0   = 4'b0100,
        ST_FB0     = 4'b0101,
        ST_FB1     = 4'b0110,
        ST_RST0    = 4'b0111,
        ST_LOCK1   = 4'b1000,
        ST_RST1    = 4'b1011,
        ST_LOCKALL = 4'b1100,
        ST_RSTALL  = 4'b1111
    } stat_mode_t;

endpackage

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic pol_pos,
    input  logic cp_hiz,
    input  logic pwr_dn,
    output logic pump_up,
    output logic pump_dn,
    output logic lead,
    output logic cmp_done
);

    pd_state_t state, state_nx;
    logic      ref_d, fb_d;
    logic      ref_evt, fb_evt;
    logic      ref_side, fb_side, quiet;

    assign ref_evt = ref_in & ~ref_d;
    assign fb_evt  = fb_in  & ~fb_d;

    // state register and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_IDLE;
            ref_d <= 1'b0;
            fb_d  <= 1'b0;
        end else begin
            state <= state_nx;
            ref_d <= ref_in;
            fb_d  <= fb_in;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PD_IDLE, PD_BOTH: begin
                if (ref_evt && fb_evt) state_nx = PD_BOTH;
                else if (ref_evt)      state_nx = PD_REF_LEAD;
                else if (fb_evt)       state_nx = PD_FB_LEAD;
                else                   state_nx = PD_IDLE;
            end
            PD_REF_LEAD: begin
                if (fb_evt) state_nx = PD_BOTH;
                else        state_nx = PD_REF_LEAD;
            end
            PD_FB_LEAD: begin
                if (ref_evt) state_nx = PD_BOTH;
                else         state_nx = PD_FB_LEAD;
            end
            default: state_nx = PD_IDLE;
        endcase
        if (pwr_dn) state_nx = PD_IDLE;
    end

    // output logic
    always_comb begin
        ref_side = (state == PD_REF_LEAD) || (state == PD_BOTH);
        fb_side  = (state == PD_FB_LEAD)  || (state == PD_BOTH);
        quiet    = cp_hiz | pwr_dn;
        pump_up  = !quiet && (pol_pos ? ref_side : fb_side);
        pump_dn  = !quiet && (pol_pos ? fb_side : ref_side);
        lead     = (state == PD_REF_LEAD) || (state == PD_FB_LEAD);
        cmp_done = (state == PD_BOTH);
    end

    // R4: the AND reset clears the both-active condition one clock later
    assert_and_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_BOTH && !(ref_evt && fb_evt)) |=> (state != PD_BOTH));

    // R5: a powered-down channel has no comparison pending
    assert_pd_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (state == PD_IDLE || !$past(pwr_dn)));

    // R5: no request reaches the pump while silenced
    assert_quiet_pump_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_hiz || pwr_dn) |-> !(pump_up || pump_dn));

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
    import pfd_lock_pkg::*;
#(
    parameter int LOCK_THRESH = 3,
    parameter int LOCK_COUNT  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lead,
    input  logic cmp_done,
    input  logic pwr_dn,
    output logic locked,
    output logic lock_view
);

    localparam int WMAX  = LOCK_THRESH + 1;
    localparam int WW    = $clog2(WMAX + 1);
    localparam int GW    = $clog2(LOCK_COUNT + 1);

    lk_state_t     lk_st, lk_nx;
    logic [WW-1:0] wcnt, wcnt_nx;
    logic [GW-1:0] good, good_nx;
    logic          too_wide, good_cmp;

    always_comb begin
        too_wide = lead && (wcnt >= WW'(LOCK_THRESH));
        good_cmp = cmp_done && (wcnt <= WW'(LOCK_THRESH));
    end

    // lead-width counter, saturating just above the limit
    always_comb begin
        if (lead) wcnt_nx = (wcnt == WW'(WMAX)) ? wcnt : wcnt + 1'b1;
        else      wcnt_nx = '0;
    end

    // lock state machine transitions
    always_comb begin
        lk_nx   = lk_st;
        good_nx = good;
        unique case (lk_st)
            LK_HUNT: begin
                if (good_cmp) begin
                    good_nx = (good == GW'(LOCK_COUNT)) ? good : good + 1'b1;
                    if (good_nx >= GW'(LOCK_COUNT)) lk_nx = LK_HELD;
                end else if (cmp_done || too_wide) begin
                    good_nx = '0;
                end
            end
            LK_HELD: begin
                if (too_wide || (cmp_done && !good_cmp)) begin
                    lk_nx   = LK_HUNT;
                    good_nx = '0;
                end
            end
            default: lk_nx = LK_HUNT;
        endcase
        if (pwr_dn) begin
            lk_nx   = LK_HUNT;
            good_nx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_st <= LK_HUNT;
            wcnt  <= '0;
            good  <= '0;
        end else begin
            lk_st <= lk_nx;
            wcnt  <= pwr_dn ? '0 : wcnt_nx;
            good  <= good_nx;
        end
    end

    always_comb begin
        locked    = (lk_st == LK_HELD);
        lock_view = locked && !lead;
    end

    // R7: an over-wide lead removes lock on the next clock
    assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        too_wide |=> !locked);

    // R6: the run counter never passes its target
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        good <= GW'(LOCK_COUNT));

    // R6: lock is only gained at the end of a comparison
    assert_lock_gain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmp_done));

endmodule

// File: rtl/status_select.sv
module status_select
    import pfd_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [NUM_CH-1:0] lock_view,
    input  logic [NUM_CH-1:0] ref_in,
    input  logic [NUM_CH-1:0] fb_in,
    output logic             stat_out,
    output logic             fast_lock,
    output logic [NUM_CH-1:0] cnt_rst
);

    stat_mode_t mode;

    always_comb begin
        mode      = stat_mode_t'(sel);
        stat_out  = 1'b0;
        fast_lock = 1'b0;
        cnt_rst   = '0;
        case (mode)
            ST_LOCK0:   stat_out = lock_view[0];
            ST_LOCK1:   stat_out = lock_view[1];
            ST_LOCKALL: stat_out = &lock_view;
            ST_REF0:    stat_out = ref_in[0];
            ST_REF1:    stat_out = ref_in[1];
            ST_FB0:     stat_out = fb_in[0];
            ST_FB1:     stat_out = fb_in[1];
            ST_FAST:    fast_lock = 1'b1;
            ST_RST0:    cnt_rst = 2'b01;
            ST_RST1:    cnt_rst = 2'b10;
            ST_RSTALL:  cnt_rst = 2'b11;
            default:    stat_out = 1'b0;
        endcase
    end

    // R11: the fast-lock request holds the pin low
    assert_fast_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fast_lock |-> !stat_out);

    // R12: counter reset and fast-lock never coexist; pin is low under reset
    assert_rst_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rst != '0) |-> (!fast_lock && !stat_out));

endmodule

// File: rtl/pfd_lock_mux.sv
module pfd_lock_mux
    import pfd_lock_pkg::*;
#(
    parameter int LOCK_THRESH = 3,
    parameter int LOCK_COUNT  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_pulse,
    input  logic [1:0] fb_pulse,
    input  logic [1:0] pol_pos,
    input  logic [1:0] cp_hiz,
    input  logic [1:0] pwr_dn,
    input  logic [3:0] stat_sel,
    output logic [1:0] pump_up,
    output logic [1:0] pump_dn,
    output logic [1:0] locked,
    output logic       stat_out,
    output logic       fast_lock,
    output logic [1:0] cnt_rst
);

    logic [NUM_CH-1:0] lead, cmp_done, lock_view;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pfd_core u_pfd (
            .clk      (clk),
            .rst_n    (rst_n),
            .ref_in   (ref_pulse[ch]),
            .fb_in    (fb_pulse[ch]),
            .pol_pos  (pol_pos[ch]),
            .cp_hiz   (cp_hiz[ch]),
            .pwr_dn   (pwr_dn[ch]),
            .pump_up  (pump_up[ch]),
            .pump_dn  (pump_dn[ch]),
            .lead     (lead[ch]),
            .cmp_done (cmp_done[ch])
        );

        lock_monitor #(
            .LOCK_THRESH (LOCK_THRESH),
            .LOCK_COUNT  (LOCK_COUNT)
        ) u_lock (
            .clk       (clk),
            .rst_n     (rst_n),
            .lead      (lead[ch]),
            .cmp_done  (cmp_done[ch]),
            .pwr_dn    (pwr_dn[ch]),
            .locked    (locked[ch]),
            .lock_view (lock_view[ch])
        );
    end

    status_select u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (stat_sel),
        .lock_view (lock_view),
        .ref_in    (ref_pulse),
        .fb_in     (fb_pulse),
        .stat_out  (stat_out),
        .fast_lock (fast_lock),
        .cnt_rst   (cnt_rst)
    );

endmodule

// File: tb/tb_pfd_lock_mux.sv
module tb_pfd_lock_mux;

    localparam int CLK_PERIOD = 10;
    localparam int THR = 2;
    localparam int CNT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_pulse = '0, fb_pulse = '0, pol_pos = 2'b11;
    logic [1:0] cp_hiz = '0, pwr_dn = '0;
    logic [3:0] stat_sel = '0;
    logic [1:0] pump_up, pump_dn, locked, cnt_rst;
    logic       stat_out, fast_lock;
    int         checks = 0, errors = 0;
    bit         finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_lock_mux #(.LOCK_THRESH(THR), .LOCK_COUNT(CNT)) dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
        .pol_pos(pol_pos), .cp_hiz(cp_hiz), .pwr_dn(pwr_dn), .stat_sel(stat_sel),
        .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked),
        .stat_out(stat_out), .fast_lock(fast_lock), .cnt_rst(cnt_rst)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_pulse = '0; fb_pulse = '0; cp_hiz = '0; pwr_dn = '0;
        pol_pos = 2'b11; stat_sel = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    // one comparison on channel ch with lead d (reference first)
    task automatic run_cmp(input int ch, input int d);
        if (d == 0) begin
            ref_pulse[ch] = 1'b1; fb_pulse[ch] = 1'b1;
            tick();
            ref_pulse[ch] = 1'b0; fb_pulse[ch] = 1'b0;
        end else begin
            ref_pulse[ch] = 1'b1;
            tick();
            ref_pulse[ch] = 1'b0;
            repeat (d - 1) tick();
            fb_pulse[ch] = 1'b1;
            tick();
            fb_pulse[ch] = 1'b0;
        end
        tick(); tick();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        check("R1 pump_up", pump_up, 0);
        check("R1 pump_dn", pump_dn, 0);
        check("R1 locked", locked, 0);
        check("R1 stat_out/fast/rst", {stat_out, fast_lock, cnt_rst}, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_ref_lead();
        do_reset();
        ref_pulse[0] = 1'b1;
        tick();
        ref_pulse[0] = 1'b0;
        check("R2 up after ref edge", pump_up[0], 1);
        check("R2 dn after ref edge", pump_dn[0], 0);
        tick(); tick();
        check("R2 up held", pump_up[0], 1);
        fb_pulse[0] = 1'b1;
        tick();
        fb_pulse[0] = 1'b0;
        check("R2 up last clock", pump_up[0], 1);
        check("R2 dn last clock", pump_dn[0], 1);
        tick();
        check("R4 both cleared", {pump_up[0], pump_dn[0]}, 0);
    endtask

    task automatic t_pol_neg();
        do_reset();
        pol_pos[1] = 1'b0;
        fb_pulse[1] = 1'b1;
        tick();
        fb_pulse[1] = 1'b0;
        check("R3 up on fb lead", pump_up[1], 1);
        check("R3 dn on fb lead", pump_dn[1], 0);
        ref_pulse[1] = 1'b1;
        tick();
        ref_pulse[1] = 1'b0;
        check("R3 both at end", {pump_up[1], pump_dn[1]}, 3);
        tick();
        check("R3 cleared", {pump_up[1], pump_dn[1]}, 0);
        ref_pulse[1] = 1'b1;
        tick();
        ref_pulse[1] = 1'b0;
        check("R3 ref lead gives dn", {pump_up[1], pump_dn[1]}, 1);
        run_cmp(1, 0);
    endtask

    task automatic t_simul();
        do_reset();
        ref_pulse[0] = 1'b1; fb_pulse[0] = 1'b1;
        tick();
        ref_pulse[0] = 1'b0; fb_pulse[0] = 1'b0;
        check("R4 one clock both", {pump_up[0], pump_dn[0]}, 3);
        tick();
        check("R4 both low next", {pump_up[0], pump_dn[0]}, 0);
    endtask

    task automatic t_freq();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            ref_pulse[0] = 1'b1;
            tick();
            ref_pulse[0] = 1'b0;
            tick();
            check("R8 up kept under repeated ref", {pump_up[0], pump_dn[0]}, 2);
        end
        run_cmp(0, 0);
    endtask

    task automatic t_hiz_pd();
        do_reset();
        ref_pulse[0] = 1'b1;
        tick();
        ref_pulse[0] = 1'b0;
        cp_hiz[0] = 1'b1;
        #1;
        check("R5 hiz silences up", {pump_up[0], pump_dn[0]}, 0);
        cp_hiz[0] = 1'b0;
        #1;
        check("R5 hiz release resumes", pump_up[0], 1);
        pwr_dn[0] = 1'b1;
        tick();
        check("R5 pd silences", {pump_up[0], pump_dn[0]}, 0);
        pwr_dn[0] = 1'b0;
        tick();
        check("R5 pending dropped", {pump_up[0], pump_dn[0]}, 0);
        for (int k = 0; k < CNT; k++) run_cmp(0, 0);
        check("R5 lock before pd", locked[0], 1);
        pwr_dn[0] = 1'b1;
        tick();
        pwr_dn[0] = 1'b0;
        tick();
        check("R5 pd clears lock", locked[0], 0);
    endtask

    task automatic t_lock();
        do_reset();
        for (int k = 0; k < CNT - 1; k++) run_cmp(0, 1);
        check("R6 not yet locked", locked[0], 0);
        run_cmp(0, 1);
        check("R6 locked after run", locked[0], 1);
        run_cmp(0, THR);
        check("R6 limit width keeps lock", locked[0], 1);
        stat_sel = 4'b0100;
        #1;
        check("R9 lock view high idle", stat_out, 1);
        ref_pulse[0] = 1'b1;
        tick();
        ref_pulse[0] = 1'b0;
        check("R9 lock view low in lead", stat_out, 0);
        fb_pulse[0] = 1'b1;
        tick();
        fb_pulse[0] = 1'b0;
        tick();
        check("R9 lock view back high", stat_out, 1);
        run_cmp(0, THR + 2);
        check("R7 wide lead drops lock", locked[0], 0);
        check("R9 view low unlocked", stat_out, 0);
        for (int k = 0; k < CNT - 1; k++) run_cmp(0, 0);
        check("R7 run restarts", locked[0], 0);
        run_cmp(0, 0);
        check("R7 relock", locked[0], 1);
    endtask

    task automatic t_lock_and();
        do_reset();
        for (int k = 0; k < CNT; k++) run_cmp(1, 0);
        stat_sel = 4'b1000;
        #1;
        check("R9 ch1 view", stat_out, 1);
        stat_sel = 4'b1100;
        #1;
        check("R9 AND with ch0 unlocked", stat_out, 0);
        for (int k = 0; k < CNT; k++) run_cmp(0, 0);
        check("R9 AND both locked", stat_out, 1);
    endtask

    task automatic t_route();
        do_reset();
        ref_pulse = 2'b01; fb_pulse = 2'b00;
        stat_sel = 4'b0001; #1;
        check("R10 ref0 high", stat_out, 1);
        stat_sel = 4'b0010; #1;
        check("R10 ref1 low", stat_out, 0);
        ref_pulse = 2'b10; #1;
        check("R10 ref1 high", stat_out, 1);
        ref_pulse = 2'b00; fb_pulse = 2'b01;
        stat_sel = 4'b0101; #1;
        check("R10 fb0 high", stat_out, 1);
        stat_sel = 4'b0110; #1;
        check("R10 fb1 low", stat_out, 0);
        fb_pulse = 2'b10; #1;
        check("R10 fb1 high", stat_out, 1);
        fb_pulse = 2'b00;
        tick(); tick();
    endtask

    task automatic t_fast_rst();
        do_reset();
        ref_pulse = 2'b11;
        stat_sel = 4'b0011; #1;
        check("R11 fast pin/req", {stat_out, fast_lock, cnt_rst}, 4'b0100);
        stat_sel = 4'b0111; #1;
        check("R12 rst ch0", {stat_out, fast_lock, cnt_rst}, 4'b0001);
        stat_sel = 4'b1011; #1;
        check("R12 rst ch1", {stat_out, fast_lock, cnt_rst}, 4'b0010);
        stat_sel = 4'b1111; #1;
        check("R12 rst both", {stat_out, fast_lock, cnt_rst}, 4'b0011);
        stat_sel = 4'b0000; #1;
        check("R13 off code", {stat_out, fast_lock, cnt_rst}, 0);
        stat_sel = 4'b1001; #1;
        check("R13 code 1001", {stat_out, fast_lock, cnt_rst}, 0);
        stat_sel = 4'b1010; #1;
        check("R13 code 1010", {stat_out, fast_lock, cnt_rst}, 0);
        stat_sel = 4'b1101; #1;
        check("R13 code 1101", {stat_out, fast_lock, cnt_rst}, 0);
        stat_sel = 4'b1110; #1;
        check("R13 code 1110", {stat_out, fast_lock, cnt_rst}, 0);
        ref_pulse = 2'b00;
        tick(); tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ref_lead();
        t_pol_neg();
        t_simul();
        t_freq();
        t_hiz_pd();
        t_lock();
        t_lock_and();
        t_route();
        t_fast_rst();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule